// File: doc/BRIEF.md
# Event Performance Counter Unit

This block is a bank of one to four event counters for a processor core. Each counter is paired with a 32-bit control word that picks one of 64 event inputs, says which privilege levels (and the exception level) count, optionally limits counting to one virtual processor or one thread context, and enables an interrupt. A counter adds one in every clock cycle in which its chosen event input is high and all of its filters pass. Both words of every slot are read and written through a small indexed register port.

Overflow is defined by the top bit of a counter, not by a wrap to zero. Software arms a slot by writing 0x80000000 minus N, so bit 31 turns on after exactly N counted events. The interrupt line is a level: it is the OR, over all slots, of (interrupt enable AND counter bit 31). It stays high until software rewrites the counter or the control word. The top bit of each control word is read-only and reads 1 when another slot follows, so software can walk the chain to learn how many slots exist.

Top module: `perf_event_unit`

## Requirements
- R1: After a synchronous reset every control word and every counter is zero, `irq` is 0 and `rd_data` is 0. On read, a control word still shows its read-only chain bit (see R2).
- R2: A control write stores bits 10:0 and 30:16 of `wr_data`. Bits 15:11 always read 0. Bit 31 ignores writes and reads 1 only for slots with index below NUM_CTR-1.
- R3: A counter adds exactly one in a cycle when the event input selected by control bits 10:5 is high and the mode and thread filters pass (R4, R5). Otherwise it holds its value. It never steps by more than one per cycle.
- R4: Mode filter. `priv` encodes 0 = kernel, 1 = supervisor, 2 = user, 3 = none. The filter passes when the control bit for the current level is set (bit 1 kernel, bit 2 supervisor, bit 3 user), or when `exl` is high and control bit 0 is set.
- R5: Thread filter, set by control bits 21:20. 0 passes always. 1 passes when bits 19:16 equal `cur_vpe`. 2 passes when bits 29:22 equal `cur_tc`. 3 never passes.
- R6: `irq` is high exactly when some slot has control bit 4 set and counter bit 31 set. A counter preset to 0x80000000-N raises `irq` after its Nth counted event.
- R7: Counting continues past bit 31 without saturating and wraps from 0xFFFFFFFF to 0. The wrap clears that slot's request.
- R8: When a counter write and a counted event fall in the same cycle, the counter takes the written value.
- R9: Writing a counter value with bit 31 clear removes that slot's request. Writing zero to a control word stops the counter.
- R10: `rd_data` is registered. It shows, one cycle after the access, the value the addressed word held before that clock edge. `reg_sel` selects 0 = control, 1 = counter. Indices at or above NUM_CTR read 0 and ignore writes.
- R11: `has_counters` reads 1, to report that counters are implemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 2 | Slot index for register access |
| reg_sel | input | 1 | 0 = control word, 1 = counter |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| events | input | 64 | Event inputs, one per event number |
| exl | input | 1 | Exception level is active |
| priv | input | 2 | Current privilege level |
| cur_vpe | input | 4 | Current virtual-processor ID |
| cur_tc | input | 8 | Current thread-context ID |
| irq | output | 1 | Level interrupt request |
| has_counters | output | 1 | Counters implemented |

## Verification
Directed sequences drive one event with a single filter changed at a time. Examples are a matching privilege against a non-matching one, the exception-level bit off and then on, and a virtual-processor or thread-context ID that differs by one and then matches. Each of these isolates one term of the count condition. Presets just below bit 31 and just below the wrap tell a correct count-to-overflow apart from an off-by-one. A write made while the event is high shows whether the write wins. A long random phase mixes events, modes, IDs and writes against a behavioural model on every clock, which exposes wrong field positions and ordering errors that the directed cases do not reach.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int REG_W    = 32;
  localparam int IDX_W    = 2;
  localparam int MAX_SLOT = 1 << IDX_W;
  localparam int EVT_W    = 6;
  localparam int EVT_N    = 1 << EVT_W;
  localparam int VPE_W    = 4;
  localparam int TC_W     = 8;

  localparam int B_EXL    = 0;
  localparam int B_KER    = 1;
  localparam int B_SUP    = 2;
  localparam int B_USR    = 3;
  localparam int B_IE     = 4;
  localparam int EVT_LO   = 5;
  localparam int VPE_LO   = 16;
  localparam int FLT_LO   = 20;
  localparam int TC_LO    = 22;
  localparam int B_MORE   = 31;
  localparam int B_OVF    = 31;

  localparam logic [REG_W-1:0] CTL_WMASK = 32'h7FFF_07FF;

  typedef enum logic [1:0] {
    PRIV_KERNEL = 2'd0,
    PRIV_SUPER  = 2'd1,
    PRIV_USER   = 2'd2,
    PRIV_NONE   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    THR_ALL  = 2'd0,
    THR_VPE  = 2'd1,
    THR_TC   = 2'd2,
    THR_OFF  = 2'd3
  } thr_flt_e;
endpackage

// File: rtl/perf_qual.sv
module perf_qual
  import perf_pkg::*;
(
  input  logic [REG_W-1:0] ctl,
  input  logic [EVT_N-1:0] events,
  input  logic             exl,
  input  logic [1:0]       priv,
  input  logic [VPE_W-1:0] cur_vpe,
  input  logic [TC_W-1:0]  cur_tc,
  output logic             hit
);
  logic [EVT_W-1:0] evt_idx;
  logic             evt_on;
  logic             mode_ok;
  logic             thr_ok;
  thr_flt_e         flt;

  always_comb begin
    evt_idx = ctl[EVT_LO +: EVT_W];
    evt_on  = events[evt_idx];
    flt     = thr_flt_e'(ctl[FLT_LO +: 2]);

    mode_ok = exl & ctl[B_EXL];
    unique case (priv_e'(priv))
      PRIV_KERNEL: mode_ok = mode_ok | ctl[B_KER];
      PRIV_SUPER:  mode_ok = mode_ok | ctl[B_SUP];
      PRIV_USER:   mode_ok = mode_ok | ctl[B_USR];
      default:     mode_ok = mode_ok;
    endcase

    unique case (flt)
      THR_ALL: thr_ok = 1'b1;
      THR_VPE: thr_ok = (ctl[VPE_LO +: VPE_W] == cur_vpe);
      THR_TC:  thr_ok = (ctl[TC_LO +: TC_W] == cur_tc);
      default: thr_ok = 1'b0;
    endcase

    hit = evt_on & mode_ok & thr_ok;
  end
endmodule

// File: rtl/perf_slot.sv
module perf_slot
  import perf_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int NUM_CTR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctl,
  input  logic             wr_cnt,
  input  logic [REG_W-1:0] wr_data,
  input  logic [EVT_N-1:0] events,
  input  logic             exl,
  input  logic [1:0]       priv,
  input  logic [VPE_W-1:0] cur_vpe,
  input  logic [TC_W-1:0]  cur_tc,
  output logic [REG_W-1:0] ctl_rd,
  output logic [REG_W-1:0] cnt_rd,
  output logic             irq_req
);
  localparam logic HAS_NEXT = (IDX < NUM_CTR - 1);

  logic [REG_W-1:0] ctl_q;
  logic [REG_W-1:0] cnt_q;
  logic             hit;

  perf_qual u_qual (
    .ctl     (ctl_q),
    .events  (events),
    .exl     (exl),
    .priv    (priv),
    .cur_vpe (cur_vpe),
    .cur_tc  (cur_tc),
    .hit     (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wr_data & CTL_WMASK;
      if (wr_cnt)   cnt_q <= wr_data;
      else if (hit) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    ctl_rd         = ctl_q;
    ctl_rd[B_MORE] = HAS_NEXT;
    cnt_rd         = cnt_q;
    irq_req        = ctl_q[B_IE] & cnt_q[B_OVF];
  end

  // R8: a counter write overrides a same-cycle increment
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt_q == $past(wr_data));

  // R3: at most one step per cycle
  assert_step_le1_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_cnt |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 32'd1));

  // R5: thread filter 3 blocks counting
  assert_flt_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && ctl_q[FLT_LO +: 2] == 2'b11) |=> $stable(cnt_q));

  // R9: rewriting the counter below bit 31 drops the request
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt && !wr_data[B_OVF]) |=> !irq_req);

  // R9: zero control word stops the counter
  assert_ctl_zero_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && wr_data == '0 && !wr_cnt) |=> ##1 (wr_cnt || $stable(cnt_q)) || $past(wr_cnt));
endmodule

// File: rtl/perf_event_unit.sv
module perf_event_unit
  import perf_pkg::*;
#(
  parameter int NUM_CTR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [EVT_N-1:0] events,
  input  logic             exl,
  input  logic [1:0]       priv,
  input  logic [VPE_W-1:0] cur_vpe,
  input  logic [TC_W-1:0]  cur_tc,
  output logic             irq,
  output logic             has_counters
);
  logic [REG_W-1:0]    ctl_a [MAX_SLOT];
  logic [REG_W-1:0]    cnt_a [MAX_SLOT];
  logic [MAX_SLOT-1:0] irq_vec;
  logic [REG_W-1:0]    rd_q;

  for (genvar i = 0; i < MAX_SLOT; i++) begin : g_slot
    if (i < NUM_CTR) begin : g_live
      logic sel_me;
      assign sel_me = wr_en && (reg_idx == IDX_W'(i));
      perf_slot #(.IDX(i), .NUM_CTR(NUM_CTR)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .wr_ctl  (sel_me && !reg_sel),
        .wr_cnt  (sel_me && reg_sel),
        .wr_data (wr_data),
        .events  (events),
        .exl     (exl),
        .priv    (priv),
        .cur_vpe (cur_vpe),
        .cur_tc  (cur_tc),
        .ctl_rd  (ctl_a[i]),
        .cnt_rd  (cnt_a[i]),
        .irq_req (irq_vec[i])
      );
    end else begin : g_absent
      assign ctl_a[i]   = '0;
      assign cnt_a[i]   = '0;
      assign irq_vec[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= reg_sel ? cnt_a[reg_idx] : ctl_a[reg_idx];
  end

  assign rd_data      = rd_q;
  assign irq          = |irq_vec;
  assign has_counters = (NUM_CTR > 0);

  // R10: absent slots read as zero
  assert_oob_read_R10: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, reg_idx} >= (IDX_W+1)'(NUM_CTR)) |=> rd_data == '0);
endmodule

// File: tb/perf_event_unit_tb.sv
module perf_event_unit_tb_top;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  idx;
  logic        sel;
  logic        wr;
  logic [31:0] wd;
  logic [31:0] rd_data;
  logic [63:0] ev;
  logic        exl;
  logic [1:0]  priv;
  logic [3:0]  vpe;
  logic [7:0]  tc;
  logic        irq;
  logic        has_counters;

  int checks = 0;
  int bad    = 0;

  logic [31:0] m_ctl [4];
  logic [31:0] m_cnt [4];
  logic [31:0] m_rd;

  always #10 clk = ~clk;

  perf_event_unit #(.NUM_CTR(N)) dut_i (
    .clk(clk), .rst(rst), .reg_idx(idx), .reg_sel(sel), .wr_en(wr),
    .wr_data(wd), .rd_data(rd_data), .events(ev), .exl(exl), .priv(priv),
    .cur_vpe(vpe), .cur_tc(tc), .irq(irq), .has_counters(has_counters)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_qual(input logic [31:0] c);
    bit e, m, t;
    e = ev[c[10:5]];
    m = 1'b0;
    if (exl && c[0]) m = 1'b1;
    if (priv == 2'd0 && c[1]) m = 1'b1;
    if (priv == 2'd1 && c[2]) m = 1'b1;
    if (priv == 2'd2 && c[3]) m = 1'b1;
    case (c[21:20])
      2'd0: t = 1'b1;
      2'd1: t = (c[19:16] == vpe);
      2'd2: t = (c[29:22] == tc);
      default: t = 1'b0;
    endcase
    return e && m && t;
  endfunction

  function automatic bit m_irq();
    bit r = 1'b0;
    for (int i = 0; i < N; i++) if (m_ctl[i][4] && m_cnt[i][31]) r = 1'b1;
    return r;
  endfunction

  // one clock: model update at the edge, compare at the falling edge (R3 R6 R10)
  task automatic step();
    bit hit [4];
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_ctl[i] = 0; m_cnt[i] = 0; end
      m_rd = 0;
    end else begin
      if (idx >= N) m_rd = 0;
      else if (sel) m_rd = m_cnt[idx];
      else m_rd = m_ctl[idx] | ((idx < N-1) ? 32'h8000_0000 : 32'h0);
      for (int i = 0; i < N; i++) hit[i] = m_qual(m_ctl[i]);
      for (int i = 0; i < N; i++) begin
        if (wr && idx == i && !sel) m_ctl[i] = wd & 32'h7FFF_07FF;
        if (wr && idx == i && sel) m_cnt[i] = wd;
        else if (hit[i]) m_cnt[i] = m_cnt[i] + 1;
      end
    end
    @(negedge clk);
    chk(rd_data === m_rd, "R10 R3 model rd_data", rd_data, m_rd);
    chk(irq === m_irq(), "R6 model irq", {31'd0, irq}, {31'd0, m_irq()});
  endtask

  task automatic wreg(input logic [1:0] i, input logic s, input logic [31:0] d);
    idx = i; sel = s; wr = 1'b1; wd = d;
    step();
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] i, input logic s, input logic [31:0] exp, input string tag);
    logic [63:0] save;
    save = ev; ev = '0; idx = i; sel = s; wr = 1'b0;
    step();
    chk(rd_data === exp, tag, rd_data, exp);
    ev = save;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; idx = 0; sel = 0; wr = 0; wd = 0; ev = '0;
    exl = 0; priv = 2'd0; vpe = 0; tc = 0;
    step(); step();
    rst = 1'b0;

    // R1 reset state
    rd_chk(0, 0, 32'h8000_0000, "R1 ctl0 after reset");
    rd_chk(1, 0, 32'h8000_0000, "R1 ctl1 after reset");
    rd_chk(2, 0, 32'h0000_0000, "R1 ctl2 after reset");
    rd_chk(0, 1, 0, "R1 cnt0 after reset");
    rd_chk(2, 1, 0, "R1 cnt2 after reset");
    chk(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
    chk(has_counters === 1'b1, "R11 has_counters", {31'd0, has_counters}, 1);

    // R2 field masking and chain bit
    wreg(0, 0, 32'hFFFF_FFFF);
    rd_chk(0, 0, 32'hFFFF_07FF, "R2 ctl0 mask");
    wreg(2, 0, 32'hFFFF_FFFF);
    rd_chk(2, 0, 32'h7FFF_07FF, "R2 ctl2 mask, last slot");
    wreg(0, 0, 0); wreg(2, 0, 0);

    // R6 preset N=3 below bit 31
    wreg(0, 1, 32'h7FFF_FFFD);
    wreg(0, 0, 32'h0000_00B2);
    ev = 64'h1 << 5;
    step(); chk(irq === 1'b0, "R6 after 1 event", {31'd0, irq}, 0);
    step(); chk(irq === 1'b0, "R6 after 2 events", {31'd0, irq}, 0);
    step(); chk(irq === 1'b1, "R6 after 3 events", {31'd0, irq}, 1);
    ev = '0;
    rd_chk(0, 1, 32'h8000_0000, "R6 count at overflow");

    // R8 write wins, R9 clear
    ev = 64'h1 << 5;
    wreg(0, 1, 0);
    chk(irq === 1'b0, "R9 irq cleared by write", {31'd0, irq}, 0);
    rd_chk(0, 1, 0, "R8 write beats increment");

    // R4 mode filter
    priv = 2'd2; ev = 64'h1 << 5;
    step(); step();
    rd_chk(0, 1, 0, "R4 user mode not enabled");
    ev = '0; exl = 1'b1;
    wreg(0, 0, 32'h0000_00B3);
    ev = 64'h1 << 5;
    step();
    rd_chk(0, 1, 1, "R4 exception level counts");
    ev = '0; exl = 1'b0; priv = 2'd0;

    // R9 stop by zero control
    wreg(0, 0, 0);
    ev = 64'h1 << 5;
    step(); step();
    rd_chk(0, 1, 1, "R9 zero control stops");
    ev = '0;

    // R5 thread filters
    wreg(1, 0, 32'h0013_00E2);
    ev = 64'h1 << 7; vpe = 4'd2;
    step(); rd_chk(1, 1, 0, "R5 vpe mismatch");
    vpe = 4'd3;
    step(); rd_chk(1, 1, 1, "R5 vpe match");
    ev = '0;
    wreg(1, 0, 32'h16A0_00E2);
    ev = 64'h1 << 7; tc = 8'h5B;
    step(); rd_chk(1, 1, 1, "R5 tc mismatch");
    tc = 8'h5A;
    step(); rd_chk(1, 1, 2, "R5 tc match");
    ev = '0;
    wreg(1, 0, 32'h0030_00E2);
    ev = 64'h1 << 7;
    step(); rd_chk(1, 1, 2, "R5 filter 3 never");
    ev = '0;

    // R7 wrap
    wreg(1, 0, 32'h0000_0012);
    wreg(1, 1, 32'hFFFF_FFFE);
    chk(irq === 1'b1, "R6 preset above bit 31", {31'd0, irq}, 1);
    ev = 64'h1;
    step(); chk(irq === 1'b1, "R7 still pending at all ones", {31'd0, irq}, 1);
    step(); chk(irq === 1'b0, "R7 wrap clears request", {31'd0, irq}, 0);
    ev = '0;
    rd_chk(1, 1, 0, "R7 wrapped to zero");

    // R10 absent slot and registered read
    wreg(3, 1, 32'h1234);
    rd_chk(3, 1, 0, "R10 absent counter");
    wreg(3, 0, 32'hFFFF);
    rd_chk(3, 0, 0, "R10 absent control");
    wreg(2, 1, 5);
    chk(rd_data === 0, "R10 read shows pre-edge value", rd_data, 0);
    rd_chk(2, 1, 5, "R10 read after write");

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      ev   = {$urandom, $urandom};
      exl  = ($urandom % 4) == 0;
      priv = 2'($urandom);
      vpe  = 4'($urandom % 4);
      tc   = 8'($urandom % 4);
      idx  = 2'($urandom);
      sel  = 1'($urandom);
      wr   = ($urandom % 8) == 0;
      if (sel) begin
        case ($urandom % 3)
          0: wd = 32'h7FFF_FFF0 + ($urandom % 16);
          1: wd = 32'hFFFF_FFF0 + ($urandom % 16);
          default: wd = $urandom;
        endcase
      end else begin
        wd = $urandom & 32'h00F3_07FF;
        wd[29:22] = 8'($urandom % 4);
        wd[19:16] = 4'($urandom % 4);
      end
      step();
    end
    wr = 0;

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule